// File: doc/BRIEF.md
# Reset-Time Pad Option Loader

This block configures the pads of a small microcontroller right after reset. When reset is released it fetches a handful of option bytes from a reserved window at the top of program memory. The window is the top 256 bytes, 7F00h to 7FFFh, of a 15-bit address space; program code lives below it. It reads them through a simple synchronous ROM read port and latches them into per-bit pad options. Each option bit picks one of two pad setups:
- 0 selects an open-drain output with no pull-up.
- 1 selects a push-pull output with a pull-up.

A separate byte carries the pull-up options of the 5-bit auxiliary port. Bit 4 of that port can never have a pull-up.

Until every option byte is in hand, the CPU is held stalled and every option output stays at the safe default: open-drain and no pull-up. All options, the run enable and a one-cycle done strobe are then released together in a single cycle. The CPU starts from address zero once run goes high. A reset during loading aborts the sequence and restores the safe default. Loading takes a few clock cycles, which is far inside the few-millisecond budget allowed after reset.

Top module: `port_option_loader`

## Requirements
- R1: While reset (rst, active high, synchronous) is sampled high, the following outputs are all 0 from the next cycle on: run, done, rom_en, every opt_pp bit and every p7_pu bit.
- R2: During a load, the block reads exactly seven addresses, each once, with rom_en high for one cycle per read on consecutive cycles. For port k (k = 0..5) it reads 7F00h + k, and for the auxiliary port it reads 7F10h. No other address, inside or outside the window, is read, so unmapped bytes have no effect on any output.
- R3: After release, opt_pp[8k+j] equals bit j of the byte at 7F00h + k. Here 1 means push-pull with pull-up and 0 means open-drain without pull-up.
- R4: After release, p7_pu[j] equals bit j of the byte at 7F10h for j = 0..3, and p7_pu[4] is 0 at all times, even when that byte is FFh.
- R5: Before release, run is 0 and opt_pp and p7_pu stay all zero. All of them change only in the release cycle.
- R6: Count rising edges from the first one at which rst is sampled low, calling it edge 1. done is high only after edge 10 and only for that one cycle. run, opt_pp and p7_pu take their loaded values at that same edge.
- R7: Once high, run stays high until rst is sampled high. run never rises without done being high in the same cycle.
- R8: If rst is sampled high at any edge up to and including edge 10, the load is aborted. done never pulses, all outputs return to the R1 values, and the next release of reset starts a complete fresh load obeying R2 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_en | output | 1 | ROM read strobe |
| rom_addr | output | 15 | ROM byte address |
| rom_rdata | input | 8 | ROM data, valid the cycle after the ROM samples rom_en |
| opt_pp | output | 48 | Per-bit pad option, ports 0 to 5, 8 bits each; 1 = push-pull with pull-up |
| p7_pu | output | 5 | Auxiliary port pull-up enables; bit 4 is always 0 |
| run | output | 1 | CPU run enable |
| done | output | 1 | One-cycle strobe marking load completion |

## Verification
Two events can fall in the same cycle: a reset assertion and the release of the loaded options with the done strobe. The bench sweeps the edge at which reset is re-asserted over every edge of the load, including the release edge itself (edge 10) and the first edge after it. Reset must win whenever it is sampled at or before the release edge, so no done pulse and no non-default option may appear. At edge 11 the release has already happened and must then be cleared. Each abort is followed by a clean load whose result is compared with option bytes computed arithmetically from the bench's ROM formula.

// File: rtl/pol_pkg.sv
`timescale 1ns/1ps
package pol_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_DRAIN,
    S_COMMIT,
    S_RUN
  } ld_state_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/pol_seq.sv
`timescale 1ns/1ps
module pol_seq
  import pol_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter logic [ADDR_W-1:0] OPT_BASE = 15'h7F00,
  parameter int NPORT = 6,
  parameter int PORT_OFS = 0,
  parameter int P7_OFS = 16,
  parameter int NREAD = NPORT + 1,
  parameter int IDX_W = $clog2(NREAD)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              rom_en,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              cap_vld,
  output logic [IDX_W-1:0]  cap_idx,
  output logic              commit
);
  localparam int CNT_W = $clog2(NREAD + 1);

  ld_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] iss_idx;

  function automatic int ofs_of(input int i);
    return (i < NPORT) ? (PORT_OFS + i) : P7_OFS;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      rom_en   <= 1'b0;
      rom_addr <= '0;
      cnt      <= '0;
      iss_idx  <= '0;
      cap_vld  <= 1'b0;
      cap_idx  <= '0;
    end else begin
      cap_vld <= rom_en;
      cap_idx <= iss_idx;
      case (state)
        S_IDLE: begin
          rom_en   <= 1'b1;
          rom_addr <= OPT_BASE + ADDR_W'(ofs_of(0));
          iss_idx  <= '0;
          cnt      <= CNT_W'(1);
          state    <= S_FETCH;
        end
        S_FETCH: begin
          if (cnt == CNT_W'(NREAD)) begin
            rom_en <= 1'b0;
            state  <= S_DRAIN;
          end else begin
            rom_addr <= OPT_BASE + ADDR_W'(ofs_of(int'(cnt)));
            iss_idx  <= IDX_W'(cnt);
            cnt      <= cnt + CNT_W'(1);
          end
        end
        S_DRAIN: begin
          if (cap_vld && cap_idx == IDX_W'(NREAD - 1)) state <= S_COMMIT;
        end
        S_COMMIT: state <= S_RUN;
        default:  state <= S_RUN;
      endcase
    end
  end

  assign commit = (state == S_COMMIT);
endmodule

// File: rtl/pol_capture.sv
`timescale 1ns/1ps
module pol_capture
  import pol_pkg::*;
#(
  parameter int NPORT = 6,
  parameter int PORT_W = 8,
  parameter int P7_W = 5,
  parameter int NREAD = NPORT + 1,
  parameter int IDX_W = $clog2(NREAD),
  parameter int SH_W = NPORT * PORT_W + P7_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_vld,
  input  logic [IDX_W-1:0]  cap_idx,
  input  logic [BYTE_W-1:0] rdata,
  output logic [SH_W-1:0]   shadow
);
  for (genvar g = 0; g < NREAD; g++) begin : g_slot
    localparam int W   = (g < NPORT) ? PORT_W : P7_W;
    localparam int LSB = (g < NPORT) ? g * PORT_W : NPORT * PORT_W;
    always_ff @(posedge clk) begin
      if (rst) shadow[LSB +: W] <= '0;
      else if (cap_vld && cap_idx == IDX_W'(g)) shadow[LSB +: W] <= rdata[W-1:0];
    end
  end
endmodule

// File: rtl/pol_release.sv
`timescale 1ns/1ps
module pol_release #(
  parameter int NPORT = 6,
  parameter int PORT_W = 8,
  parameter int P7_W = 5,
  parameter int P7_NOPU = 4,
  parameter int SH_W = NPORT * PORT_W + P7_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    commit,
  input  logic [SH_W-1:0]         shadow,
  output logic [NPORT*PORT_W-1:0] opt_pp,
  output logic [P7_W-1:0]         p7_pu,
  output logic                    run,
  output logic                    done
);
  localparam logic [P7_W-1:0] P7_MASK = ~(P7_W'(1) << P7_NOPU);

  for (genvar k = 0; k < NPORT; k++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) opt_pp[k*PORT_W +: PORT_W] <= '0;
      else if (commit) opt_pp[k*PORT_W +: PORT_W] <= shadow[k*PORT_W +: PORT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p7_pu <= '0;
      run   <= 1'b0;
      done  <= 1'b0;
    end else begin
      if (commit) p7_pu <= shadow[NPORT*PORT_W +: P7_W] & P7_MASK;
      done <= commit;
      run  <= run | commit;
    end
  end
endmodule

// File: rtl/port_option_loader.sv
`timescale 1ns/1ps
module port_option_loader #(
  parameter int ADDR_W = 15,
  parameter logic [ADDR_W-1:0] OPT_BASE = 15'h7F00,
  parameter int NPORT = 6,
  parameter int PORT_W = 8,
  parameter int P7_W = 5,
  parameter int P7_NOPU = 4,
  parameter int PORT_OFS = 0,
  parameter int P7_OFS = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic                    rom_en,
  output logic [ADDR_W-1:0]       rom_addr,
  input  logic [7:0]              rom_rdata,
  output logic [NPORT*PORT_W-1:0] opt_pp,
  output logic [P7_W-1:0]         p7_pu,
  output logic                    run,
  output logic                    done
);
  localparam int NREAD = NPORT + 1;
  localparam int IDX_W = $clog2(NREAD);
  localparam int SH_W  = NPORT * PORT_W + P7_W;

  logic             cap_vld;
  logic [IDX_W-1:0] cap_idx;
  logic             commit;
  logic [SH_W-1:0]  shadow;

  pol_seq #(
    .ADDR_W(ADDR_W), .OPT_BASE(OPT_BASE), .NPORT(NPORT),
    .PORT_OFS(PORT_OFS), .P7_OFS(P7_OFS), .NREAD(NREAD), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst(rst), .rom_en(rom_en), .rom_addr(rom_addr),
    .cap_vld(cap_vld), .cap_idx(cap_idx), .commit(commit)
  );

  pol_capture #(
    .NPORT(NPORT), .PORT_W(PORT_W), .P7_W(P7_W),
    .NREAD(NREAD), .IDX_W(IDX_W), .SH_W(SH_W)
  ) u_cap (
    .clk(clk), .rst(rst), .cap_vld(cap_vld), .cap_idx(cap_idx),
    .rdata(rom_rdata), .shadow(shadow)
  );

  pol_release #(
    .NPORT(NPORT), .PORT_W(PORT_W), .P7_W(P7_W), .P7_NOPU(P7_NOPU), .SH_W(SH_W)
  ) u_rel (
    .clk(clk), .rst(rst), .commit(commit), .shadow(shadow),
    .opt_pp(opt_pp), .p7_pu(p7_pu), .run(run), .done(done)
  );
endmodule

// File: rtl/pol_checker.sv
`timescale 1ns/1ps
module pol_checker #(
  parameter int ADDR_W = 15,
  parameter logic [ADDR_W-1:0] OPT_BASE = 15'h7F00,
  parameter int NPORT = 6,
  parameter int PORT_W = 8,
  parameter int P7_W = 5,
  parameter int P7_NOPU = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    rom_en,
  input logic [ADDR_W-1:0]       rom_addr,
  input logic [NPORT*PORT_W-1:0] opt_pp,
  input logic [P7_W-1:0]         p7_pu,
  input logic                    run,
  input logic                    done
);
  p_window_r2: assert property (@(posedge clk) disable iff (rst)
    rom_en |-> rom_addr[ADDR_W-1:8] == OPT_BASE[ADDR_W-1:8]);

  p_no_p7b4_r4: assert property (@(posedge clk) disable iff (rst)
    p7_pu[P7_NOPU] == 1'b0);

  p_safe_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !run |-> (opt_pp == '0 && p7_pu == '0));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_run_hold_r7: assert property (@(posedge clk) disable iff (rst)
    run |=> run);

  p_rise_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> done);

  p_no_read_after_run_r2: assert property (@(posedge clk) disable iff (rst)
    run |-> !rom_en);
endmodule

bind port_option_loader pol_checker #(
  .ADDR_W(ADDR_W), .OPT_BASE(OPT_BASE), .NPORT(NPORT),
  .PORT_W(PORT_W), .P7_W(P7_W), .P7_NOPU(P7_NOPU)
) u_chk (
  .clk(clk), .rst(rst), .rom_en(rom_en), .rom_addr(rom_addr),
  .opt_pp(opt_pp), .p7_pu(p7_pu), .run(run), .done(done)
);

// File: tb/port_option_loader_tb.sv
`timescale 1ns/1ps
module port_option_loader_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rom_en;
  logic [14:0] rom_addr;
  logic [7:0]  rom_rdata = 8'h00;
  logic [47:0] opt_pp;
  logic [4:0]  p7_pu;
  logic        run, done;

  int tests = 0, fails = 0;
  logic [7:0] seed = 8'h00;
  int rom_mode = 0;
  int bad_reads = 0, dup_reads = 0;
  logic [6:0] seen = '0;

  always #10 clk = ~clk;

  port_option_loader u_dut (
    .clk(clk), .rst(rst), .rom_en(rom_en), .rom_addr(rom_addr),
    .rom_rdata(rom_rdata), .opt_pp(opt_pp), .p7_pu(p7_pu),
    .run(run), .done(done)
  );

  function automatic logic [7:0] rom_byte(input logic [14:0] a, input logic [7:0] s, input int m);
    if (a[14:8] != 7'h7F) return 8'hC3;
    if (m == 1) return 8'hFF;
    if (m == 2) return 8'h00;
    return 8'((a[7:0] * 8'd29) + 8'd7) ^ s;
  endfunction

  always @(posedge clk) begin
    if (rom_en) rom_rdata <= rom_byte(rom_addr, seed, rom_mode);
    if (!rst && rom_en) begin
      int k;
      k = -1;
      for (int i = 0; i < 6; i++) if (rom_addr == 15'h7F00 + 15'(i)) k = i;
      if (rom_addr == 15'h7F10) k = 6;
      if (k < 0) bad_reads++;
      else begin
        if (seen[k]) dup_reads++;
        seen[k] = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] exp_opt();
    logic [47:0] v;
    for (int k = 0; k < 6; k++) v[k*8 +: 8] = rom_byte(15'h7F00 + 15'(k), seed, rom_mode);
    return v;
  endfunction

  function automatic logic [4:0] exp_p7();
    logic [7:0] b;
    b = rom_byte(15'h7F10, seed, rom_mode);
    return b[4:0] & 5'b01111;
  endfunction

  // abort_at = 0: no abort; otherwise rst is sampled high at edge abort_at
  task automatic run_load(input logic [7:0] s, input int m, input int abort_at);
    logic [54:0] act, expv, zero;
    @(negedge clk);
    rst = 1'b1;
    seed = s;
    rom_mode = m;
    bad_reads = 0;
    dup_reads = 0;
    seen = '0;
    @(negedge clk);
    zero = '0;
    act = {run, done, p7_pu, opt_pp};
    chk(act == zero && !rom_en, "R1 reset state", {8'h0, rom_en, act}, 64'h0);
    rst = 1'b0;
    for (int e = 1; e <= 12; e++) begin
      if (abort_at != 0 && e == abort_at) rst = 1'b1;
      @(negedge clk);
      act = {run, done, p7_pu, opt_pp};
      if (abort_at != 0 && e >= abort_at) begin
        chk(act == zero, "R8 abort keeps default", 64'(act), 64'h0);
      end else if (e < 10) begin
        chk(act == zero, "R5 default before release", 64'(act), 64'h0);
      end else if (e == 10) begin
        chk(run && done, "R6 release at edge 10", {62'h0, run, done}, 64'h3);
        chk(opt_pp == exp_opt(), "R3 port options", 64'(opt_pp), 64'(exp_opt()));
        chk(p7_pu == exp_p7(), "R4 aux pull-ups", 64'(p7_pu), 64'(exp_p7()));
      end else begin
        expv = {1'b1, 1'b0, exp_p7(), exp_opt()};
        chk(act == expv, "R7 run holds, done drops", 64'(act), 64'(expv));
      end
    end
    if (abort_at == 0) begin
      chk(seen == 7'h7F && bad_reads == 0 && dup_reads == 0, "R2 read map",
          {32'(bad_reads), 16'(dup_reads), 9'h0, seen}, 64'h7F);
    end
  endtask

  initial begin
    for (int s = 0; s < 256; s++) run_load(8'(s), 0, 0);
    run_load(8'h00, 1, 0);
    run_load(8'h00, 2, 0);
    for (int k = 1; k <= 11; k++) begin
      run_load(8'(k * 17), 1, k);
      run_load(8'(k * 31), 0, 0);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule